// File: doc/BRIEF.md
# Edge interrupt controller

The block watches up to 96 asynchronous input pins, grouped into three banks of 32, and turns their edges into interrupt requests. For each line, software picks rising edges, falling edges, both, or neither. Every pin goes through a two-stage synchronizer before edge detection. A detected rising edge sets a bit in the bank's rising-pending register, and a detected falling edge sets a bit in the separate falling-pending register. Software clears a pending bit by writing a one to it.

Each line drives three outputs:
- a masked interrupt request, which stays high while the line has a pending bit set and its interrupt-mask bit is set;
- a share of a per-bank level request, which is the OR of the bank's masked line requests;
- a one-cycle event pulse per detected edge, gated only by the line's event-mask bit.

Software can also raise a rising-pending bit directly through a software-trigger register. A build parameter marks which lines exist. On absent lines, the trigger-select bits never store a one, so writing all ones and reading back shows which lines are present.

Registers are reached through a simple port: a write strobe, an address, write data and combinational read data. All registers reset to zero.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Per bank k, the registers are at the following byte addresses; reads from any other address return 0, and mask registers read back exactly the value written:
  - rising-select at 0x00+0x20k;
  - falling-select at 0x04+0x20k;
  - software-trigger at 0x08+0x20k;
  - rising-pending at 0x0C+0x20k;
  - falling-pending at 0x10+0x20k;
  - interrupt-mask at 0x80+0x10k;
  - event-mask at 0x84+0x10k.
- R2: For a line whose bit in the presence parameter is 0, writes of one to its rising-select and falling-select bits are ignored (the bits read 0), and that line never sets a pending bit or raises its interrupt.
- R3: A 0-to-1 pin change on a line with its rising-select bit set is first visible in rising-pending after the third rising clock edge that follows the change, and not after the first.
- R4: A 1-to-0 pin change on a line with its falling-select bit set sets its falling-pending bit with the same latency. Rising and falling events land in separate registers, and a line armed for both gets a bit in each.
- R5: A line with both select bits clear sets no pending bit and produces no event pulse, whatever its pin does.
- R6: Writing a one to a pending bit clears it, and writing zero leaves it unchanged. Writing all ones clears every pending bit of that bank.
- R7: When a detected edge and a write-one-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R8: Writing ones to software-trigger sets the corresponding rising-pending bits of present lines in the same write cycle, so they are readable right after the write. Software-trigger itself always reads 0 and never sets falling-pending.
- R9: Line n drives irq_line[n] high exactly while line n has a pending bit set and its interrupt-mask bit is 1. irq_bank[k] is the OR of the 32 requests of bank k. Clearing a mask bit does not clear pending.
- R10: With its event-mask bit set, a line pulses event_pulse for one cycle. The pulse appears after the second rising clock edge that follows the pin change, one cycle before the pending bit shows, and it does not depend on the interrupt mask.
- R11: After reset, every register reads 0 and all interrupt and event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| line_in | input | 96 | Asynchronous interrupt pins, line n at bit n |
| irq_line | output | 96 | Masked per-line interrupt requests |
| irq_bank | output | 3 | Per-bank combined level request |
| event_pulse | output | 96 | Per-line one-cycle event pulses |

## Verification
A sweep visits every one of the 96 lines in turn and arms only that line for rising edges. This checks the three-cycle latency, the event-pulse cycle, the one-hot position of the request, and that absent lines stay silent.

Directed patterns then cover the remaining behaviour:
- Pins armed for falling only and for both edges show that the two pending registers are independent.
- An unarmed pin shows that no select means no event.
- Write-one-to-clear is tried with zero, partial and all-ones data.
- A clear timed into the exact cycle of an edge shows that the edge takes priority.
- The mask and the event mask are toggled separately on a held pending bit, which separates interrupt gating from event gating.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int LANES  = 32;
  localparam int BIDX_W = 2;

  typedef enum logic [2:0] {
    RK_NONE, RK_RSEL, RK_FSEL, RK_SWT, RK_RPEND, RK_FPEND, RK_IMASK, RK_EMASK
  } reg_kind_t;

  typedef struct packed {
    reg_kind_t         kind;
    logic [BIDX_W-1:0] bank;
  } reg_sel_t;

  // Trigger/pending group: bank stride 0x20; mask group: base 0x80, stride 0x10.
  function automatic reg_sel_t decode_addr(input logic [7:0] a, input int nbanks);
    reg_sel_t s;
    s = '{kind: RK_NONE, bank: '0};
    if (!a[7]) begin
      s.bank = a[6:5];
      case (a[4:0])
        5'h00:   s.kind = RK_RSEL;
        5'h04:   s.kind = RK_FSEL;
        5'h08:   s.kind = RK_SWT;
        5'h0C:   s.kind = RK_RPEND;
        5'h10:   s.kind = RK_FPEND;
        default: s.kind = RK_NONE;
      endcase
    end else begin
      s.bank = a[5:4];
      if (!a[6]) begin
        case (a[3:0])
          4'h0:    s.kind = RK_IMASK;
          4'h4:    s.kind = RK_EMASK;
          default: s.kind = RK_NONE;
        endcase
      end
    end
    if (int'(s.bank) >= nbanks) s.kind = RK_NONE;
    return s;
  endfunction

  // Pending update: clear by ones, new events take priority over the clear.
  function automatic logic [LANES-1:0] w1c_update(input logic [LANES-1:0] cur,
                                                  input logic [LANES-1:0] clr,
                                                  input logic [LANES-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/eic_edge_sync.sv
module eic_edge_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/eic_bank.sv
module eic_bank
  import eic_pkg::*;
#(
  parameter logic [LANES-1:0] AVAIL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_rsel,
  input  logic             wr_fsel,
  input  logic             wr_swt,
  input  logic             wr_rclr,
  input  logic             wr_fclr,
  input  logic             wr_imask,
  input  logic             wr_emask,
  input  logic [LANES-1:0] wdata,
  input  logic [LANES-1:0] rise_det,
  input  logic [LANES-1:0] fall_det,
  output logic [LANES-1:0] rsel_q,
  output logic [LANES-1:0] fsel_q,
  output logic [LANES-1:0] rpend_q,
  output logic [LANES-1:0] fpend_q,
  output logic [LANES-1:0] imask_q,
  output logic [LANES-1:0] emask_q,
  output logic [LANES-1:0] hit_rise,
  output logic [LANES-1:0] hit_fall,
  output logic [LANES-1:0] irq_line,
  output logic [LANES-1:0] event_pulse,
  output logic             irq_any
);
  logic [LANES-1:0] sw_set, rclr, fclr;

  assign sw_set   = wr_swt  ? (wdata & AVAIL) : '0;
  assign rclr     = wr_rclr ? wdata : '0;
  assign fclr     = wr_fclr ? wdata : '0;
  assign hit_rise = rise_det & rsel_q;
  assign hit_fall = fall_det & fsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q  <= '0;
      fsel_q  <= '0;
      rpend_q <= '0;
      fpend_q <= '0;
      imask_q <= '0;
      emask_q <= '0;
    end else begin
      if (wr_rsel)  rsel_q  <= wdata & AVAIL;
      if (wr_fsel)  fsel_q  <= wdata & AVAIL;
      if (wr_imask) imask_q <= wdata;
      if (wr_emask) emask_q <= wdata;
      rpend_q <= w1c_update(rpend_q, rclr, hit_rise | sw_set);
      fpend_q <= w1c_update(fpend_q, fclr, hit_fall);
    end
  end

  assign irq_line    = (rpend_q | fpend_q) & imask_q;
  assign irq_any     = |irq_line;
  assign event_pulse = (hit_rise | hit_fall) & emask_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter logic [NUM_BANKS*32-1:0] LINE_PRESENT =
    {32'h00F0_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [7:0]                   reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic [NUM_BANKS*LANES-1:0]   line_in,
  output logic [NUM_BANKS*LANES-1:0]   irq_line,
  output logic [NUM_BANKS-1:0]         irq_bank,
  output logic [NUM_BANKS*LANES-1:0]   event_pulse
);
  localparam int NL = NUM_BANKS * LANES;

  reg_sel_t dec;
  assign dec = decode_addr(reg_addr, NUM_BANKS);

  logic [NL-1:0] rise_all, fall_all, rp_all, fp_all, hr_all, hf_all;
  logic [NUM_BANKS-1:0] wr_rsel, wr_fsel, sw_wr, rpclr_wr, fpclr_wr, wr_imask, wr_emask;
  logic [LANES-1:0] rsel_b [NUM_BANKS];
  logic [LANES-1:0] fsel_b [NUM_BANKS];
  logic [LANES-1:0] imask_b [NUM_BANKS];
  logic [LANES-1:0] emask_b [NUM_BANKS];

  eic_edge_sync #(.W(NL)) u_sync (
    .clk (clk), .rst_n (rst_n), .pin (line_in), .rise (rise_all), .fall (fall_all)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic sel_k;
    assign sel_k       = reg_wr && (dec.bank == BIDX_W'(k));
    assign wr_rsel[k]  = sel_k && (dec.kind == RK_RSEL);
    assign wr_fsel[k]  = sel_k && (dec.kind == RK_FSEL);
    assign sw_wr[k]    = sel_k && (dec.kind == RK_SWT);
    assign rpclr_wr[k] = sel_k && (dec.kind == RK_RPEND);
    assign fpclr_wr[k] = sel_k && (dec.kind == RK_FPEND);
    assign wr_imask[k] = sel_k && (dec.kind == RK_IMASK);
    assign wr_emask[k] = sel_k && (dec.kind == RK_EMASK);

    eic_bank #(.AVAIL(LINE_PRESENT[k*LANES +: LANES])) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_rsel     (wr_rsel[k]),
      .wr_fsel     (wr_fsel[k]),
      .wr_swt      (sw_wr[k]),
      .wr_rclr     (rpclr_wr[k]),
      .wr_fclr     (fpclr_wr[k]),
      .wr_imask    (wr_imask[k]),
      .wr_emask    (wr_emask[k]),
      .wdata       (reg_wdata),
      .rise_det    (rise_all[k*LANES +: LANES]),
      .fall_det    (fall_all[k*LANES +: LANES]),
      .rsel_q      (rsel_b[k]),
      .fsel_q      (fsel_b[k]),
      .rpend_q     (rp_all[k*LANES +: LANES]),
      .fpend_q     (fp_all[k*LANES +: LANES]),
      .imask_q     (imask_b[k]),
      .emask_q     (emask_b[k]),
      .hit_rise    (hr_all[k*LANES +: LANES]),
      .hit_fall    (hf_all[k*LANES +: LANES]),
      .irq_line    (irq_line[k*LANES +: LANES]),
      .event_pulse (event_pulse[k*LANES +: LANES]),
      .irq_any     (irq_bank[k])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (dec.bank == BIDX_W'(k)) begin
        case (dec.kind)
          RK_RSEL:  reg_rdata = rsel_b[k];
          RK_FSEL:  reg_rdata = fsel_b[k];
          RK_RPEND: reg_rdata = rp_all[k*LANES +: LANES];
          RK_FPEND: reg_rdata = fp_all[k*LANES +: LANES];
          RK_IMASK: reg_rdata = imask_b[k];
          RK_EMASK: reg_rdata = emask_b[k];
          default:  reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int NUM_BANKS = 3,
  parameter logic [NUM_BANKS*32-1:0] PRESENT = '1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [31:0]               reg_wdata,
  input logic [NUM_BANKS*32-1:0]   rp_all,
  input logic [NUM_BANKS*32-1:0]   fp_all,
  input logic [NUM_BANKS*32-1:0]   hr_all,
  input logic [NUM_BANKS*32-1:0]   hf_all,
  input logic [NUM_BANKS*32-1:0]   irq_line,
  input logic [NUM_BANKS-1:0]      sw_wr,
  input logic [NUM_BANKS-1:0]      rpclr_wr,
  input logic [NUM_BANKS-1:0]      fpclr_wr
);
  assert_absent_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rp_all | fp_all) & ~PRESENT) == '0);

  assert_rise_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_all != '0) |=> ((rp_all & $past(hr_all)) == $past(hr_all)));

  assert_fall_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hf_all != '0) |=> ((fp_all & $past(hf_all)) == $past(hf_all)));

  assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line & ~(rp_all | fp_all)) == '0);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank_chk
    assert_rclear_only_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(rp_all[k*32 +: 32]) & ~rp_all[k*32 +: 32] &
        ~($past(rpclr_wr[k]) ? $past(reg_wdata) : 32'h0)) == 32'h0));

    assert_fclear_only_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(fp_all[k*32 +: 32]) & ~fp_all[k*32 +: 32] &
        ~($past(fpclr_wr[k]) ? $past(reg_wdata) : 32'h0)) == 32'h0));

    assert_swtrig_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr[k] |=> ((rp_all[k*32 +: 32] & $past(reg_wdata) & PRESENT[k*32 +: 32]) ==
                    ($past(reg_wdata) & PRESENT[k*32 +: 32])));
  end
endmodule

bind edge_irq_ctrl eic_checker #(.NUM_BANKS(NUM_BANKS), .PRESENT(LINE_PRESENT)) u_eic_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wdata (reg_wdata),
  .rp_all    (rp_all),
  .fp_all    (fp_all),
  .hr_all    (hr_all),
  .hf_all    (hf_all),
  .irq_line  (irq_line),
  .sw_wr     (sw_wr),
  .rpclr_wr  (rpclr_wr),
  .fpclr_wr  (fpclr_wr)
);

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam logic [95:0] AVAIL = {32'h00F0_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [95:0] pins = '0;
  logic [95:0] irq_line, event_pulse;
  logic [2:0]  irq_bank;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl #(.NUM_BANKS(NB), .LINE_PRESENT(AVAIL)) i_edge_irq_ctrl (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .line_in (pins),
    .irq_line (irq_line), .irq_bank (irq_bank), .event_pulse (event_pulse)
  );

  function automatic logic [7:0] a_rs(int k); return 8'(k*32 + 0);  endfunction
  function automatic logic [7:0] a_fs(int k); return 8'(k*32 + 4);  endfunction
  function automatic logic [7:0] a_sw(int k); return 8'(k*32 + 8);  endfunction
  function automatic logic [7:0] a_rp(int k); return 8'(k*32 + 12); endfunction
  function automatic logic [7:0] a_fp(int k); return 8'(k*32 + 16); endfunction
  function automatic logic [7:0] a_im(int k); return 8'(128 + k*16); endfunction
  function automatic logic [7:0] a_em(int k); return 8'(132 + k*16); endfunction

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, 96'(v), 96'(exp));
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    for (int k = 0; k < NB; k++) begin
      rdchk("R11 rsel", a_rs(k), 0); rdchk("R11 fsel", a_fs(k), 0);
      rdchk("R11 swt", a_sw(k), 0);  rdchk("R11 rpend", a_rp(k), 0);
      rdchk("R11 fpend", a_fp(k), 0); rdchk("R11 imask", a_im(k), 0);
      rdchk("R11 emask", a_em(k), 0);
    end
    chk("R11 irq_line", irq_line, '0);
    chk("R11 irq_bank", 96'(irq_bank), '0);
    chk("R11 event", event_pulse, '0);

    // R1 / R2: mask readback and line probing
    for (int k = 0; k < NB; k++) begin
      wr(a_im(k), 32'hA5A5_0000 ^ 32'(k));
      wr(a_em(k), ~(32'h5A5A_0000 ^ 32'(k)));
      rdchk("R1 imask readback", a_im(k), 32'hA5A5_0000 ^ 32'(k));
      rdchk("R1 emask readback", a_em(k), ~(32'h5A5A_0000 ^ 32'(k)));
      wr(a_rs(k), 32'hFFFF_FFFF);
      wr(a_fs(k), 32'hFFFF_FFFF);
      rdchk("R2 rsel probe", a_rs(k), AVAIL[k*32 +: 32]);
      rdchk("R2 fsel probe", a_fs(k), AVAIL[k*32 +: 32]);
      wr(a_rs(k), 0); wr(a_fs(k), 0); wr(a_im(k), 0); wr(a_em(k), 0);
    end
    rdchk("R1 unmapped", 8'h14, 0);
    rdchk("R1 unmapped", 8'hC0, 0);

    // Per-line sweep: R3, R9, R10, R2, R5, R6
    for (int n = 0; n < 96; n++) begin
      int k;
      int b;
      logic [31:0] m;
      logic [95:0] one_n;
      logic pres;
      k = n / 32; b = n % 32; m = 32'h1 << b; one_n = 96'h1 << n; pres = AVAIL[n];
      wr(a_rs(k), m); wr(a_em(k), m); wr(a_im(k), m);
      pins[n] = 1'b1;
      @(negedge clk);
      rdchk("R3 pend not early", a_rp(k), 0);
      @(negedge clk);
      chk("R10 event cycle", event_pulse, pres ? one_n : '0);
      @(negedge clk);
      rdchk(pres ? "R3 rise latched" : "R2 absent no pend", a_rp(k), pres ? m : 0);
      chk("R10 event one cycle", event_pulse, '0);
      chk("R9 irq_line", irq_line, pres ? one_n : '0);
      chk("R9 irq_bank", 96'(irq_bank), pres ? 96'(3'b001 << k) : '0);
      pins[n] = 1'b0;
      wait_n(4);
      rdchk("R5 unarmed fall", a_fp(k), 0);
      wr(a_rp(k), m);
      rdchk("R6 cleared", a_rp(k), 0);
      chk("R9 irq_bank low", 96'(irq_bank), '0);
      wr(a_rs(k), 0); wr(a_em(k), 0); wr(a_im(k), 0);
    end

    // R4: both edges on line 5, falling-only on line 40
    wr(a_rs(0), 32'h20); wr(a_fs(0), 32'h20);
    pins[5] = 1'b1; wait_n(3);
    rdchk("R4 both rise", a_rp(0), 32'h20);
    rdchk("R4 both no fall yet", a_fp(0), 0);
    pins[5] = 1'b0; wait_n(3);
    rdchk("R4 both fall", a_fp(0), 32'h20);
    rdchk("R4 rise kept", a_rp(0), 32'h20);
    wr(a_rp(0), 32'hFFFF_FFFF); wr(a_fp(0), 32'hFFFF_FFFF);
    rdchk("R6 all ones rp", a_rp(0), 0);
    rdchk("R6 all ones fp", a_fp(0), 0);
    wr(a_rs(0), 0); wr(a_fs(0), 0);
    wr(a_fs(1), 32'h100);
    pins[40] = 1'b1; wait_n(3);
    rdchk("R4 fall-only ignores rise", a_rp(1), 0);
    rdchk("R4 fall-only no fpend", a_fp(1), 0);
    pins[40] = 1'b0; wait_n(3);
    rdchk("R4 fall-only fpend", a_fp(1), 32'h100);
    rdchk("R4 fall-only rpend", a_rp(1), 0);
    wr(a_fp(1), 32'h100); wr(a_fs(1), 0);

    // R5: unarmed line with event mask set
    wr(a_em(0), 32'h80);
    pins[7] = 1'b1; wait_n(2);
    chk("R5 no event", event_pulse, '0);
    wait_n(2);
    pins[7] = 1'b0; wait_n(4);
    rdchk("R5 no rpend", a_rp(0), 0);
    rdchk("R5 no fpend", a_fp(0), 0);
    wr(a_em(0), 0);

    // R6 / R8: partial clears
    wr(a_sw(0), 32'hF0);
    rdchk("R8 sw sets", a_rp(0), 32'hF0);
    wr(a_rp(0), 0);
    rdchk("R6 zero no effect", a_rp(0), 32'hF0);
    wr(a_rp(0), 32'h30);
    rdchk("R6 partial clear", a_rp(0), 32'hC0);
    wr(a_rp(0), 32'hFFFF_FFFF);
    rdchk("R6 full clear", a_rp(0), 0);
    wr(a_sw(1), 32'h8001);
    rdchk("R8 sw bank1", a_rp(1), 32'h8001);
    rdchk("R8 sw reads zero", a_sw(1), 0);
    wr(a_rp(1), 32'hFFFF_FFFF);
    wr(a_sw(2), 32'hFFFF_FFFF);
    rdchk("R8 sw absent masked", a_rp(2), AVAIL[95:64]);
    rdchk("R8 sw no fpend", a_fp(2), 0);
    wr(a_rp(2), 32'hFFFF_FFFF);

    // R7: edge and clear in the same cycle
    wr(a_rs(0), 32'h8);
    wr(a_sw(0), 32'h8);
    pins[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a_rp(0); reg_wdata = 32'h8;
    @(negedge clk);
    reg_wr = 1'b0;
    rdchk("R7 edge wins", a_rp(0), 32'h8);
    wr(a_rp(0), 32'h8);
    rdchk("R6 clear after", a_rp(0), 0);
    pins[3] = 1'b0; wait_n(4);
    wr(a_rs(0), 0);

    // R9: mask gating on a held pending bit
    wr(a_sw(1), 32'h4);
    chk("R9 masked off", irq_line, '0);
    chk("R9 bank masked", 96'(irq_bank), '0);
    wr(a_im(1), 32'h4);
    chk("R9 unmasked", irq_line, 96'h1 << 34);
    chk("R9 bank raised", 96'(irq_bank), 96'(3'b010));
    wr(a_im(1), 0);
    chk("R9 remasked", irq_line, '0);
    rdchk("R9 pend kept", a_rp(1), 32'h4);
    wr(a_rp(1), 32'h4);

    // R10: event independent of interrupt mask
    wr(a_rs(2), 32'h1); wr(a_em(2), 32'h1);
    pins[64] = 1'b1; wait_n(2);
    chk("R10 event without imask", event_pulse, 96'h1 << 64);
    @(negedge clk);
    chk("R10 no irq", 96'(irq_bank), '0);
    wr(a_rp(2), 32'h1); wr(a_rs(2), 0); wr(a_em(2), 0); wr(a_fs(2), 32'h1);
    pins[64] = 1'b0; wait_n(2);
    chk("R10 no event when emask clear", event_pulse, '0);
    @(negedge clk);
    rdchk("R10 pend still latched", a_fp(2), 32'h1);
    wr(a_fp(2), 32'h1); wr(a_fs(2), 0);

    rd(a_rp(0), v);
    finish_run();
  end
endmodule